// File: doc/BRIEF.md
# Power-Managed Clock Source Controller

This controller decides which oscillator drives a small microcontroller-style system and which clock domains are allowed to toggle. Software or a power manager presents a mode request together with a load strobe. The controller then enables the oscillator that mode needs. Once that oscillator reports a valid clock, the controller moves the clock selection across to it. Oscillators are modelled as enable outputs paired with clock-valid inputs. Actual clock muxing and dividing happen downstream, driven by `src_sel` and `hf_div`.

The supported modes are: primary run and idle, secondary run and idle, internal run and idle, and sleep. In idle modes the core clock stops and peripherals keep running. In sleep every source is stopped, except the low-frequency internal source, which stays on while the watchdog is enabled. A wake pulse returns the controller from any idle mode, or from sleep, to the run mode of the source that was last selected.

Top module: `pm_clk_ctrl`

## Requirements
- R1: After reset the mode is internal-run (code 4), the source is the postscaled internal source (code 2), and `hf_div` reads `RESET_DIV` until the first accepted request. From then on `hf_div` follows `post_div`.
- R2: `core_clk_en` is high exactly in the run modes (primary-run 0, secondary-run 2, internal-run 4). `periph_clk_en` is high in every mode except sleep (6).
- R3: `prim_osc_en` is high only in primary-run (0) or primary-idle (1), or while a handover to the primary source (code 0) is pending.
- R4: Secondary-run (2) and secondary-idle (3) select source code 1. Outside sleep, `sec_osc_en` is high whenever that source is selected or `sec_keep` is set.
- R5: Internal-run (4) and internal-idle (5) select source code 3 with `hf_osc_en` low when `lf_direct` is set at the request. Otherwise they select source code 2.
- R6: In sleep with no handover pending, the primary, secondary and high-frequency enables are low, and `lf_osc_en` equals `wdt_en`.
- R7: A requested change takes effect only after the target source's valid input has passed two synchronising flops. The mode changes on the third rising edge after the valid rises, and the previous source stays selected until then.
- R8: A wake pulse in an idle mode (1, 3, 5) or in sleep (6) leads to the run mode of the selected source. A wake pulse in a run mode has no effect.
- R9: A request with code 7 is ignored.
- R10: Primary-idle (1) gates the core clock while the primary oscillator enable stays high and peripherals stay clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_load | input | 1 | Strobe that accepts `mode_req` |
| mode_req | input | 3 | Requested mode code (0..6, 7 ignored) |
| wake | input | 1 | Wake pulse out of idle or sleep |
| lf_direct | input | 1 | Internal modes take the low-frequency source directly |
| sec_keep | input | 1 | Keep the secondary oscillator running for timers |
| wdt_en | input | 1 | Watchdog enabled; holds the low-frequency source on |
| prim_ok | input | 1 | Primary oscillator clock valid |
| sec_ok | input | 1 | Secondary oscillator clock valid |
| hf_ok | input | 1 | High-frequency internal source valid |
| lf_ok | input | 1 | Low-frequency internal source valid |
| post_div | input | DIV_W | Postscaler ratio register |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| prim_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| hf_osc_en | output | 1 | High-frequency internal source enable |
| lf_osc_en | output | 1 | Low-frequency internal source enable |
| src_sel | output | 2 | Selected source: 0 primary, 1 secondary, 2 internal postscaled, 3 internal low-frequency |
| mode_cur | output | 3 | Mode currently in effect |
| hf_div | output | DIV_W | Postscaler ratio in effect |

## Verification
The bench builds the block with `DIV_W` = 3 and `RESET_DIV` = 3, and drives `post_div` with 5. Because the two values differ, the hand-off from the start-up ratio to the register ratio is visible at the first accepted request. With the 3-bit mode field the bench can also issue the unused code 7, so the ignore rule is exercised. The 2-bit source field lets every source, including the directly used low-frequency one, be selected and observed.

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl #(
  parameter int              DIV_W     = 3,
  parameter logic [DIV_W-1:0] RESET_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [2:0]       mode_req,
  input  logic             wake,
  input  logic             lf_direct,
  input  logic             sec_keep,
  input  logic             wdt_en,
  input  logic             prim_ok,
  input  logic             sec_ok,
  input  logic             hf_ok,
  input  logic             lf_ok,
  input  logic [DIV_W-1:0] post_div,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             prim_osc_en,
  output logic             sec_osc_en,
  output logic             hf_osc_en,
  output logic             lf_osc_en,
  output logic [1:0]       src_sel,
  output logic [2:0]       mode_cur,
  output logic [DIV_W-1:0] hf_div
);

  localparam logic [2:0] M_PRUN = 3'd0, M_PIDL = 3'd1, M_SRUN = 3'd2, M_SIDL = 3'd3;
  localparam logic [2:0] M_IRUN = 3'd4, M_IIDL = 3'd5, M_SLP  = 3'd6, M_NONE = 3'd7;
  localparam logic [1:0] S_PRI = 2'd0, S_SEC = 2'd1, S_HF = 2'd2, S_LF = 2'd3;

  logic [2:0] mode_q, pend_mode;
  logic [1:0] src_q, pend_src;
  logic       pend_vld, boot_q;
  logic [3:0] ok_vec, sync1, sync2;

  assign ok_vec = {lf_ok, hf_ok, sec_ok, prim_ok};

  function automatic logic [1:0] src_for(input logic [2:0] m, input logic lfd, input logic [1:0] cur);
    case (m)
      M_PRUN, M_PIDL: return S_PRI;
      M_SRUN, M_SIDL: return S_SEC;
      M_IRUN, M_IIDL: return lfd ? S_LF : S_HF;
      default:        return cur;
    endcase
  endfunction

  function automatic logic [2:0] run_for(input logic [1:0] s);
    case (s)
      S_PRI:   return M_PRUN;
      S_SEC:   return M_SRUN;
      default: return M_IRUN;
    endcase
  endfunction

  logic req_ok, low_mode, wake_go, ready, sleeping, pend_live;

  assign req_ok    = mode_load && (mode_req != M_NONE);
  assign low_mode  = (mode_q == M_PIDL) || (mode_q == M_SIDL) || (mode_q == M_IIDL) || (mode_q == M_SLP);
  assign wake_go   = wake && !req_ok && low_mode;
  assign ready     = (pend_mode == M_SLP) || sync2[pend_src];
  assign sleeping  = (mode_q == M_SLP);
  assign pend_live = pend_vld && (pend_mode != M_SLP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= ok_vec;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_IRUN;
      src_q     <= S_HF;
      pend_vld  <= 1'b0;
      pend_mode <= M_IRUN;
      pend_src  <= S_HF;
      boot_q    <= 1'b1;
    end else if (req_ok) begin
      pend_vld  <= 1'b1;
      pend_mode <= mode_req;
      pend_src  <= src_for(mode_req, lf_direct, src_q);
      boot_q    <= 1'b0;
    end else if (wake_go) begin
      pend_vld  <= 1'b1;
      pend_mode <= run_for(src_q);
      pend_src  <= src_q;
    end else if (pend_vld && ready) begin
      mode_q   <= pend_mode;
      src_q    <= pend_src;
      pend_vld <= 1'b0;
    end
  end

  assign core_clk_en   = (mode_q == M_PRUN) || (mode_q == M_SRUN) || (mode_q == M_IRUN);
  assign periph_clk_en = !sleeping;
  assign prim_osc_en   = (!sleeping && src_q == S_PRI) || (pend_live && pend_src == S_PRI);
  assign sec_osc_en    = (!sleeping && (src_q == S_SEC || sec_keep)) || (pend_live && pend_src == S_SEC);
  assign hf_osc_en     = (!sleeping && src_q == S_HF) || (pend_live && pend_src == S_HF);
  assign lf_osc_en     = wdt_en || (!sleeping && src_q == S_LF) || (pend_live && pend_src == S_LF);
  assign src_sel       = src_q;
  assign mode_cur      = mode_q;
  assign hf_div        = boot_q ? RESET_DIV : post_div;

  AST_PRIM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    prim_osc_en |-> (mode_q == M_PRUN || mode_q == M_PIDL || pend_vld)); // R3

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !pend_vld) |-> (!prim_osc_en && !sec_osc_en && !hf_osc_en && lf_osc_en == wdt_en)); // R6

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vld |=> $stable(src_q)); // R7

  AST_PRIM_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == S_PRI && $past(src_q) != S_PRI) |-> $past(prim_ok, 3)); // R7

  AST_CODE7_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && mode_req == M_NONE && !pend_vld && !wake) |=> !pend_vld); // R9

  AST_WAKE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !mode_load && low_mode) |=> (pend_vld && pend_mode == run_for(src_q))); // R8

  AST_PIDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PIDL) |-> (!core_clk_en && periph_clk_en && prim_osc_en)); // R10

endmodule

// File: tb/pm_clk_ctrl_tb.sv
`timescale 1ns/1ps
module pm_clk_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_load = 0, wake = 0, lf_direct = 0, sec_keep = 0, wdt_en = 0;
  logic [2:0] mode_req = 0;
  logic prim_ok = 1, sec_ok = 1, hf_ok = 1, lf_ok = 1;
  logic [2:0] post_div = 3'd5;
  logic core_clk_en, periph_clk_en, prim_osc_en, sec_osc_en, hf_osc_en, lf_osc_en;
  logic [1:0] src_sel;
  logic [2:0] mode_cur, hf_div;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_clk_ctrl #(.DIV_W(3), .RESET_DIV(3'd3)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_req(mode_req), .wake(wake),
    .lf_direct(lf_direct), .sec_keep(sec_keep), .wdt_en(wdt_en),
    .prim_ok(prim_ok), .sec_ok(sec_ok), .hf_ok(hf_ok), .lf_ok(lf_ok), .post_div(post_div),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .prim_osc_en(prim_osc_en),
    .sec_osc_en(sec_osc_en), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
    .src_sel(src_sel), .mode_cur(mode_cur), .hf_div(hf_div));

  // [18] load [17:15] req [14] wake [13] lf_direct [12] sec_keep [11] wdt_en
  // [10:8] mode [7:6] src [5] core [4] periph [3] prim [2] sec [1] hf [0] lf
  localparam logic [18:0] VEC [13] = '{
    {1'b1,3'd0,1'b0,1'b0,1'b0,1'b0, 3'd0,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0},
    {1'b1,3'd1,1'b0,1'b0,1'b0,1'b0, 3'd1,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0},
    {1'b0,3'd0,1'b1,1'b0,1'b0,1'b0, 3'd0,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0},
    {1'b1,3'd2,1'b0,1'b0,1'b0,1'b0, 3'd2,2'd1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0},
    {1'b1,3'd3,1'b0,1'b0,1'b0,1'b0, 3'd3,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0},
    {1'b1,3'd4,1'b0,1'b1,1'b0,1'b0, 3'd4,2'd3,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b1,3'd5,1'b0,1'b0,1'b0,1'b0, 3'd5,2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0},
    {1'b1,3'd6,1'b0,1'b0,1'b0,1'b1, 3'd6,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    {1'b0,3'd0,1'b1,1'b0,1'b0,1'b1, 3'd4,2'd2,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1},
    {1'b1,3'd7,1'b0,1'b0,1'b0,1'b0, 3'd4,2'd2,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 3'd4,2'd2,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0},
    {1'b1,3'd6,1'b0,1'b0,1'b1,1'b0, 3'd6,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b0,3'd0,1'b1,1'b0,1'b1,1'b0, 3'd4,2'd2,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [10:0] e);
    chk({tag, " R1/R5 mode"}, mode_cur, e[10:8]);
    chk({tag, " R4/R5 src"}, src_sel, e[7:6]);
    chk({tag, " R2 core"}, core_clk_en, e[5]);
    chk({tag, " R2 periph"}, periph_clk_en, e[4]);
    chk({tag, " R3 prim_en"}, prim_osc_en, e[3]);
    chk({tag, " R4 sec_en"}, sec_osc_en, e[2]);
    chk({tag, " R5/R6 hf_en"}, hf_osc_en, e[1]);
    chk({tag, " R6 lf_en"}, lf_osc_en, e[0]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_all("reset R1", {3'd4, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    chk("R1 start-up div", hf_div, 3);

    for (int i = 0; i < 13; i++) begin
      mode_load = VEC[i][18]; mode_req = VEC[i][17:15]; wake = VEC[i][14];
      lf_direct = VEC[i][13]; sec_keep = VEC[i][12]; wdt_en = VEC[i][11];
      @(negedge clk);
      mode_load = 0; wake = 0;
      repeat (4) @(negedge clk);
      chk_all($sformatf("vec%0d", i), VEC[i][10:0]);
      if (i == 0) chk("R1 div follows register", hf_div, 5);
    end

    // R7 handover waits for synchronised primary valid; R3 enable during pending
    prim_ok = 0;
    repeat (3) @(negedge clk);
    mode_load = 1; mode_req = 3'd0;
    @(negedge clk);
    mode_load = 0;
    repeat (5) @(negedge clk);
    chk("R7 old mode held", mode_cur, 4);
    chk("R7 old src held", src_sel, 2);
    chk("R3 prim enabled while pending", prim_osc_en, 1);
    prim_ok = 1;
    @(negedge clk);
    chk("R7 one edge after valid", mode_cur, 4);
    @(negedge clk);
    chk("R7 two edges after valid", mode_cur, 4);
    @(negedge clk);
    chk("R7 three edges after valid", mode_cur, 0);
    chk("R7 src switched", src_sel, 0);

    // R8 wake in run mode has no effect
    wake = 1;
    @(negedge clk);
    wake = 0;
    repeat (4) @(negedge clk);
    chk("R8 wake ignored in run", mode_cur, 0);
    chk("R8 src unchanged", src_sel, 0);

    // R10 primary idle keeps oscillator and peripherals
    mode_load = 1; mode_req = 3'd1;
    @(negedge clk);
    mode_load = 0;
    repeat (4) @(negedge clk);
    chk("R10 core gated", core_clk_en, 0);
    chk("R10 prim kept", prim_osc_en, 1);
    chk("R10 periph on", periph_clk_en, 1);

    // R9 code 7 ignored in idle
    mode_load = 1; mode_req = 3'd7;
    @(negedge clk);
    mode_load = 0;
    repeat (4) @(negedge clk);
    chk("R9 code 7 ignored", mode_cur, 1);

    done = 1;
    finish_run();
  end
endmodule